// File: doc/BRIEF.md
# GPIO Port Controller with Pin Interrupt Detection

This block controls one port of up to 32 general-purpose pins behind a word-wide register bus. Software uses it to set an output latch, choose the direction of each pin, turn on pull-ups, and pick a 2-bit function per pin. The pin multiplexer downstream decodes that function select. The pull-up bits and the function selects leave the block as plain control vectors.

Each pin also has a 2-bit trigger mode. The four modes are low level, high level, falling edge and rising edge. Pin levels pass through a synchronizer first. A pin that matches its trigger condition sets a sticky flag. This happens only while the pin is an input in plain GPIO function. Software clears a flag by writing a 1 to its bit. A registered port interrupt is raised while any flag is set together with its enable bit.

There are no set or clear alias registers. Every write replaces the whole register, so software changes single bits with a read-modify-write sequence.

Top module: `gpio_port_irq`

## Requirements
- R1: After reset, these registers read zero: data latch, direction, pull-up, function, trigger and interrupt enable. `pin_out`, `pin_oe`, `pin_pull` and `pin_func` are zero, and `irq` is low.
- R2: A write replaces the whole target register. The data latch is at offset 0x00 and drives `pin_out`. Direction is at 0x04 and drives `pin_oe`, where 1 means output. Pull-up is at 0x0C and drives `pin_pull`, where 1 means enabled. Interrupt enable is at 0x20. Bit N maps to pin N. A read returns the value on `bus_rdata` one clock after the read cycle.
- R3: Function selects are 2 bits per pin. Offset 0x10 holds pins 0 to 15, and pin X uses bits 2X+1:2X. Offset 0x14 holds pins 16 to 31, and pin X uses bits 2(X-16)+1:2(X-16). A function field reads back and drives `pin_func[2X+1:2X]`. The code 00 means GPIO, and 01, 10 and 11 select alternates 1 to 3.
- R4: A read of offset 0x00 returns the output latch for output pins. For input pins it returns the synchronized pin level. That level lags `pin_in` by two clocks.
- R5: Trigger fields use the same split layout as the function fields, at offsets 0x18 (lower) and 0x1C (upper). The codes are 00 for low level, 01 for high level, 10 for falling edge and 11 for rising edge. An edge is the synchronized level differing from its value one clock earlier.
- R6: A flag bit (offset 0x28) sets only when its pin is an input with function 00 and matches its trigger. It sets whatever the state of the enable bit.
- R7: Writing 1 to a bit of offset 0x28 clears that flag, and writing 0 leaves it unchanged. If a clear and a new event arrive in the same cycle, the flag stays set.
- R8: `irq` is a register that holds the OR over all pins of flag AND enable. It follows that value one clock later.
- R9: Offsets without a register read as zero, and writes to them have no effect. These include 0x08 and 0x24.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pin_in | input | NPINS | Asynchronous pin levels |
| pin_out | output | NPINS | Output latch |
| pin_oe | output | NPINS | Output enable per pin |
| pin_pull | output | NPINS | Pull-up enable per pin |
| pin_func | output | 2*NPINS | Function select per pin |
| irq | output | 1 | Registered port interrupt |

## Verification
The bench builds the block with its defaults: 32 pins and a two-stage synchronizer. With 32 pins, both the lower and upper halves of the function and trigger fields are exercised, including pin 31 at the top bit pair. With two stages, the bench can check the exact latency from a pin edge to the flag and then to `irq`. Each trigger mode is driven on its own. Level triggers are checked against clear-versus-event collisions. Output pins and pins set to an alternate function are checked to raise no flag.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  localparam int unsigned BUS_AW = 6;
  localparam int unsigned BUS_DW = 32;
  localparam int unsigned HALF_PINS = 16;

  localparam logic [BUS_AW-1:0] OFS_DATA    = 6'h00;
  localparam logic [BUS_AW-1:0] OFS_DIR     = 6'h04;
  localparam logic [BUS_AW-1:0] OFS_PULL    = 6'h0C;
  localparam logic [BUS_AW-1:0] OFS_FUNC_LO = 6'h10;
  localparam logic [BUS_AW-1:0] OFS_FUNC_HI = 6'h14;
  localparam logic [BUS_AW-1:0] OFS_TRIG_LO = 6'h18;
  localparam logic [BUS_AW-1:0] OFS_TRIG_HI = 6'h1C;
  localparam logic [BUS_AW-1:0] OFS_IEN     = 6'h20;
  localparam logic [BUS_AW-1:0] OFS_FLAG    = 6'h28;

  typedef enum logic [1:0] {
    TRIG_LOW  = 2'b00,
    TRIG_HIGH = 2'b01,
    TRIG_FALL = 2'b10,
    TRIG_RISE = 2'b11
  } trig_mode_e;

  localparam logic [1:0] FUNC_GPIO = 2'b00;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned WIDTH  = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] chain_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) chain_q[0] <= '0;
    else     chain_q[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) chain_q[s] <= '0;
      else     chain_q[s] <= chain_q[s-1];
    end
  end

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/gpio_irq_flags.sv
module gpio_irq_flags
  import gpio_port_pkg::*;
#(
  parameter int unsigned NPINS = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NPINS-1:0]   lvl,
  input  logic [NPINS-1:0]   dir,
  input  logic [2*NPINS-1:0] func,
  input  logic [2*NPINS-1:0] trig,
  input  logic [NPINS-1:0]   clr,
  output logic [NPINS-1:0]   flags
);
  logic [NPINS-1:0] prev_q;
  logic [NPINS-1:0] elig;
  logic [NPINS-1:0] evt;
  logic [NPINS-1:0] flags_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '0;
    else     prev_q <= lvl;
  end

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    trig_mode_e mode;
    logic       hit;
    assign mode    = trig_mode_e'(trig[2*i +: 2]);
    assign elig[i] = !dir[i] && (func[2*i +: 2] == FUNC_GPIO);
    always_comb begin
      unique case (mode)
        TRIG_LOW:  hit = !lvl[i];
        TRIG_HIGH: hit = lvl[i];
        TRIG_FALL: hit = prev_q[i] && !lvl[i];
        TRIG_RISE: hit = !prev_q[i] && lvl[i];
        default:   hit = 1'b0;
      endcase
    end
    assign evt[i] = hit && elig[i];
  end

  always_ff @(posedge clk) begin
    if (rst) flags_q <= '0;
    else     flags_q <= (flags_q & ~clr) | evt;
  end

  assign flags = flags_q;

  // R7: an event in a cycle leaves its flag set on the following cycle
  p_event_beats_clear_r7: assert property (@(posedge clk) disable iff (rst)
    (evt != '0) |=> ((flags_q & $past(evt)) == $past(evt)));

  // R6: a flag may only rise on a pin that was an eligible input
  p_flag_only_eligible_r6: assert property (@(posedge clk) disable iff (rst)
    !rst |=> (((flags_q & ~$past(flags_q)) & ~$past(elig)) == '0));

  // R7: a flag only drops where software wrote a 1
  p_flag_drop_needs_w1c_r7: assert property (@(posedge clk) disable iff (rst)
    !rst |=> (((~flags_q & $past(flags_q)) & ~$past(clr)) == '0));
endmodule

// File: rtl/gpio_regfile.sv
module gpio_regfile
  import gpio_port_pkg::*;
#(
  parameter int unsigned NPINS = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               bus_sel,
  input  logic               bus_we,
  input  logic [BUS_AW-1:0]  bus_addr,
  input  logic [BUS_DW-1:0]  bus_wdata,
  output logic [BUS_DW-1:0]  bus_rdata,
  input  logic [NPINS-1:0]   lvl,
  input  logic [NPINS-1:0]   flags,
  output logic [NPINS-1:0]   data_q,
  output logic [NPINS-1:0]   dir_q,
  output logic [NPINS-1:0]   pull_q,
  output logic [NPINS-1:0]   ien_q,
  output logic [2*NPINS-1:0] func_q,
  output logic [2*NPINS-1:0] trig_q,
  output logic [NPINS-1:0]   clr
);
  localparam int unsigned FULL_W = 2 * BUS_DW;

  logic              wr;
  logic              rd;
  logic [BUS_DW-1:0] rd_mux;
  logic [BUS_DW-1:0] rdata_q;
  logic [FULL_W-1:0] func_full;
  logic [FULL_W-1:0] trig_full;
  logic [NPINS-1:0]  data_view;
  logic              hole;

  assign wr = bus_sel && bus_we;
  assign rd = bus_sel && !bus_we;

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q <= '0;
      dir_q  <= '0;
      pull_q <= '0;
      ien_q  <= '0;
    end else if (wr) begin
      if (bus_addr == OFS_DATA) data_q <= bus_wdata[NPINS-1:0];
      if (bus_addr == OFS_DIR)  dir_q  <= bus_wdata[NPINS-1:0];
      if (bus_addr == OFS_PULL) pull_q <= bus_wdata[NPINS-1:0];
      if (bus_addr == OFS_IEN)  ien_q  <= bus_wdata[NPINS-1:0];
    end
  end

  for (genvar i = 0; i < NPINS; i++) begin : g_field
    localparam bit          IS_HI = (i >= HALF_PINS);
    localparam int unsigned SH    = IS_HI ? 2 * (i - HALF_PINS) : 2 * i;
    localparam logic [BUS_AW-1:0] F_OFS = IS_HI ? OFS_FUNC_HI : OFS_FUNC_LO;
    localparam logic [BUS_AW-1:0] T_OFS = IS_HI ? OFS_TRIG_HI : OFS_TRIG_LO;
    always_ff @(posedge clk) begin
      if (rst) begin
        func_q[2*i +: 2] <= '0;
        trig_q[2*i +: 2] <= '0;
      end else if (wr) begin
        if (bus_addr == F_OFS) func_q[2*i +: 2] <= bus_wdata[SH +: 2];
        if (bus_addr == T_OFS) trig_q[2*i +: 2] <= bus_wdata[SH +: 2];
      end
    end
  end

  assign clr = (wr && bus_addr == OFS_FLAG) ? bus_wdata[NPINS-1:0] : '0;

  assign func_full = FULL_W'(func_q);
  assign trig_full = FULL_W'(trig_q);
  assign data_view = (data_q & dir_q) | (lvl & ~dir_q);

  always_comb begin
    hole = 1'b0;
    case (bus_addr)
      OFS_DATA:    rd_mux = BUS_DW'(data_view);
      OFS_DIR:     rd_mux = BUS_DW'(dir_q);
      OFS_PULL:    rd_mux = BUS_DW'(pull_q);
      OFS_FUNC_LO: rd_mux = func_full[BUS_DW-1:0];
      OFS_FUNC_HI: rd_mux = func_full[FULL_W-1:BUS_DW];
      OFS_TRIG_LO: rd_mux = trig_full[BUS_DW-1:0];
      OFS_TRIG_HI: rd_mux = trig_full[FULL_W-1:BUS_DW];
      OFS_IEN:     rd_mux = BUS_DW'(ien_q);
      OFS_FLAG:    rd_mux = BUS_DW'(flags);
      default: begin
        rd_mux = '0;
        hole   = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)     rdata_q <= '0;
    else if (rd) rdata_q <= rd_mux;
  end

  assign bus_rdata = rdata_q;

  // R9: a read of an empty offset returns zero
  p_hole_reads_zero_r9: assert property (@(posedge clk) disable iff (rst)
    (rd && hole) |=> (bus_rdata == '0));

  // R2: a direction write replaces every bit
  p_dir_full_replace_r2: assert property (@(posedge clk) disable iff (rst)
    (wr && bus_addr == OFS_DIR) |=> (dir_q == $past(bus_wdata[NPINS-1:0])));

  // R9: writes to empty offsets leave the masks untouched
  p_hole_write_ignored_r9: assert property (@(posedge clk) disable iff (rst)
    (wr && hole) |=> ($stable(dir_q) && $stable(data_q) && $stable(ien_q) && $stable(pull_q)));
endmodule

// File: rtl/gpio_port_irq.sv
module gpio_port_irq
  import gpio_port_pkg::*;
#(
  parameter int unsigned NPINS       = 32,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               bus_sel,
  input  logic               bus_we,
  input  logic [5:0]         bus_addr,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  input  logic [NPINS-1:0]   pin_in,
  output logic [NPINS-1:0]   pin_out,
  output logic [NPINS-1:0]   pin_oe,
  output logic [NPINS-1:0]   pin_pull,
  output logic [2*NPINS-1:0] pin_func,
  output logic               irq
);
  logic [NPINS-1:0]   lvl;
  logic [NPINS-1:0]   flags;
  logic [NPINS-1:0]   clr;
  logic [NPINS-1:0]   data_q;
  logic [NPINS-1:0]   dir_q;
  logic [NPINS-1:0]   pull_q;
  logic [NPINS-1:0]   ien_q;
  logic [2*NPINS-1:0] func_q;
  logic [2*NPINS-1:0] trig_q;
  logic               irq_q;

  gpio_sync #(.WIDTH(NPINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (pin_in),
    .q   (lvl)
  );

  gpio_regfile #(.NPINS(NPINS)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .bus_sel   (bus_sel),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .lvl       (lvl),
    .flags     (flags),
    .data_q    (data_q),
    .dir_q     (dir_q),
    .pull_q    (pull_q),
    .ien_q     (ien_q),
    .func_q    (func_q),
    .trig_q    (trig_q),
    .clr       (clr)
  );

  gpio_irq_flags #(.NPINS(NPINS)) u_flags (
    .clk   (clk),
    .rst   (rst),
    .lvl   (lvl),
    .dir   (dir_q),
    .func  (func_q),
    .trig  (trig_q),
    .clr   (clr),
    .flags (flags)
  );

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= |(flags & ien_q);
  end

  assign pin_out  = data_q;
  assign pin_oe   = dir_q;
  assign pin_pull = pull_q;
  assign pin_func = func_q;
  assign irq      = irq_q;

  // R8: an enabled pending flag raises the line on the next clock
  p_irq_rises_r8: assert property (@(posedge clk) disable iff (rst)
    ((flags & ien_q) != '0) |=> irq);

  // R8: with nothing enabled and pending the line drops on the next clock
  p_irq_falls_r8: assert property (@(posedge clk) disable iff (rst)
    ((flags & ien_q) == '0) |=> !irq);
endmodule

// File: tb/gpio_port_irq_bench.sv
module gpio_port_irq_bench;
  logic        clk = 1'b0;
  logic        rst;
  logic        bus_sel;
  logic        bus_we;
  logic [5:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [31:0] pin_in;
  logic [31:0] pin_out;
  logic [31:0] pin_oe;
  logic [31:0] pin_pull;
  logic [63:0] pin_func;
  logic        irq;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  gpio_port_irq #(.NPINS(32), .SYNC_STAGES(2)) u_gpio_port_irq (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
    .pin_pull(pin_pull), .pin_func(pin_func), .irq(irq)
  );

  task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_sel = 1'b0;
    d = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic prep(input logic [31:0] trig_word, input logic [31:0] idle_pins);
    wr(6'h04, 32'h0);
    wr(6'h10, 32'h0);
    wr(6'h14, 32'h0);
    wr(6'h18, trig_word);
    wr(6'h1C, trig_word);
    wr(6'h20, 32'h0);
    pin_in = idle_pins;
    idle(4);
    wr(6'h28, 32'hFFFF_FFFF);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    check("R1 pin_out", pin_out, 0);
    check("R1 pin_oe", pin_oe, 0);
    check("R1 pin_pull", pin_pull, 0);
    check("R1 pin_func", pin_func, 0);
    check("R1 irq", irq, 0);
    rd(6'h04, v); check("R1 dir read", v, 0);
    rd(6'h10, v); check("R1 func lo read", v, 0);
    rd(6'h1C, v); check("R1 trig hi read", v, 0);
    rd(6'h20, v); check("R1 enable read", v, 0);
  endtask

  task automatic t_regs();
    logic [31:0] v;
    wr(6'h04, 32'hA5A5_0F0F);
    check("R2 pin_oe", pin_oe, 32'hA5A5_0F0F);
    rd(6'h04, v); check("R2 dir read", v, 32'hA5A5_0F0F);
    wr(6'h04, 32'h0000_00FF);
    rd(6'h04, v); check("R2 dir replaced", v, 32'h0000_00FF);
    wr(6'h00, 32'h1234_5678);
    check("R2 pin_out", pin_out, 32'h1234_5678);
    wr(6'h0C, 32'hC001_0003);
    check("R2 pin_pull", pin_pull, 32'hC001_0003);
    wr(6'h20, 32'h8000_0001);
    rd(6'h20, v); check("R2 enable read", v, 32'h8000_0001);
    wr(6'h20, 32'h0);
  endtask

  task automatic t_func();
    logic [31:0] v;
    wr(6'h10, 32'h0000_0006);
    wr(6'h14, 32'hC000_0000);
    check("R3 pin0 func", pin_func[1:0], 2'b10);
    check("R3 pin1 func", pin_func[3:2], 2'b01);
    check("R3 pin31 func", pin_func[63:62], 2'b11);
    check("R3 pin16 func", pin_func[33:32], 2'b00);
    rd(6'h14, v); check("R3 func hi read", v, 32'hC000_0000);
  endtask

  task automatic t_holes();
    logic [31:0] v;
    wr(6'h08, 32'hFFFF_FFFF);
    wr(6'h24, 32'hFFFF_FFFF);
    rd(6'h08, v); check("R9 0x08 read", v, 0);
    rd(6'h24, v); check("R9 0x24 read", v, 0);
    rd(6'h04, v); check("R9 dir untouched", v, 32'h0000_00FF);
    check("R9 pin_out untouched", pin_out, 32'h1234_5678);
  endtask

  task automatic t_data_view();
    logic [31:0] v;
    wr(6'h04, 32'hFFFF_0000);
    wr(6'h00, 32'hAAAA_AAAA);
    pin_in = 32'h5555_1234;
    idle(3);
    rd(6'h00, v); check("R4 mixed data read", v, 32'hAAAA_1234);
  endtask

  task automatic t_rise();
    logic [31:0] v;
    prep(32'hFFFF_FFFF, 32'h0);
    rd(6'h28, v); check("R5 rise idle flags", v, 0);
    @(negedge clk); pin_in = 32'h0000_0008;
    idle(4);
    rd(6'h28, v); check("R5 rising edge flag", v, 32'h0000_0008);
    wr(6'h28, 32'h0000_0008);
    pin_in = 32'h0;
    idle(4);
    rd(6'h28, v); check("R5 falling ignored in rise mode", v, 0);
  endtask

  task automatic t_fall();
    logic [31:0] v;
    prep(32'hAAAA_AAAA, 32'h0001_0000);
    rd(6'h28, v); check("R5 fall idle flags", v, 0);
    @(negedge clk); pin_in = 32'h0;
    idle(4);
    rd(6'h28, v); check("R5 falling edge flag", v, 32'h0001_0000);
  endtask

  task automatic t_high();
    logic [31:0] v;
    prep(32'h5555_5555, 32'h0);
    @(negedge clk); pin_in = 32'h8000_0001;
    idle(4);
    rd(6'h28, v); check("R5 high level flags", v, 32'h8000_0001);
    wr(6'h28, 32'hFFFF_FFFF);
    rd(6'h28, v); check("R7 level event beats clear", v, 32'h8000_0001);
    pin_in = 32'h0;
    idle(4);
    wr(6'h28, 32'h0000_0001);
    rd(6'h28, v); check("R7 w1c clears only bit0", v, 32'h8000_0000);
    wr(6'h28, 32'h8000_0000);
    rd(6'h28, v); check("R7 w1c clears bit31", v, 0);
  endtask

  task automatic t_low();
    logic [31:0] v;
    prep(32'h0, 32'hFFFF_FFFF);
    rd(6'h28, v); check("R5 low idle flags", v, 0);
    @(negedge clk); pin_in = 32'hFFFF_FFFE;
    idle(4);
    rd(6'h28, v); check("R5 low level flag", v, 32'h0000_0001);
  endtask

  task automatic t_elig_irq();
    logic [31:0] v;
    prep(32'h5555_5555, 32'h0);
    wr(6'h04, 32'h0000_00F0);
    wr(6'h10, 32'h0000_0001);
    @(negedge clk); pin_in = 32'h0000_00FF;
    idle(4);
    rd(6'h28, v); check("R6 only gpio inputs flag", v, 32'h0000_000E);
    check("R6 flags with enable off keep irq low", irq, 0);
    wr(6'h20, 32'h0000_0002);
    check("R8 irq not yet", irq, 0);
    @(negedge clk);
    check("R8 irq after enable", irq, 1);
    wr(6'h20, 32'h0000_0001);
    @(negedge clk);
    check("R8 irq drops with enable off", irq, 0);
    prep(32'h5555_5555, 32'h0);
    wr(6'h20, 32'h0000_0008);
    @(negedge clk); pin_in = 32'h0000_0008;
    idle(3);
    check("R8 irq latency early", irq, 0);
    idle(1);
    check("R8 irq latency on time", irq, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst = 1'b1; bus_sel = 1'b0; bus_we = 1'b0; bus_addr = '0;
    bus_wdata = '0; pin_in = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_regs();
    t_func();
    t_holes();
    t_data_view();
    t_rise();
    t_fall();
    t_high();
    t_low();
    t_elig_irq();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule